// File: doc/BRIEF.md
# Shutdown-Pin Mode Programming Decoder

This block watches two already-synchronized host pins, a shutdown line and an infrared transmit-data line. From the way the host toggles them it works out the transceiver's operating mode: low-bandwidth SIR, high-bandwidth MIR/FIR (called FAST below), or remote-control drive through the single transmit pin. It times each high pulse on the shutdown line with a clock counter. A short pulse is a programming command. A pulse of intermediate length is a protocol error. A long pulse is a full shutdown, which also returns the mode to SIR.

A programming command closes when the shutdown line falls. At that edge the block takes the transmit-data level as the bandwidth choice. A complete, wide-enough transmit-data pulse seen earlier inside the same window overrides that choice and selects remote-control drive. While the shutdown line is high, or the block is shut down, the transmit-data line is only a programming input, and the block's pass-through transmit output stays low.

The FSM has three states. ST_RUN is normal operation. ST_PROG is the shutdown line high, measuring. ST_SHUT is full shutdown. Its transitions are:
- RUN→PROG when the shutdown line is sampled high.
- PROG→RUN when the line is sampled low. This step decodes the pulse.
- PROG→SHUT when the line has been high for the shutdown threshold.
- SHUT→RUN when the line is sampled low.

All thresholds come from `CLK_HZ` and nanosecond parameters. The defaults are a 250 MHz clock, a 5000 ns programming limit, a 30000 ns shutdown threshold, a 200 ns setup time and a 200 ns minimum pulse width.

Top module: `sd_mode_decoder`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (SIR), and `shutdown_o`, `prog_busy_o` and `proto_err_o` are all 0. Mode codes are: 2'b00 SIR, 2'b01 FAST, 2'b10 remote control.
- R2: A shutdown-line high pulse of at most PROG_CYC clock cycles (1250 by default) with `txir_i` high in the first cycle `sd_i` is low sets `mode_o` to 2'b01 (FAST), provided no remote-control pulse was seen.
- R3: The same short pulse with `txir_i` low in that cycle sets `mode_o` to 2'b00 (SIR), provided no remote-control pulse was seen.
- R4: The shutdown state begins once `sd_i` has been sampled high for SHUT_CYC cycles (7500 by default). `shutdown_o` is 1 from the following cycle until the cycle after `sd_i` is sampled low. During shutdown `mode_o` is 2'b00, and it stays 2'b00 after release.
- R5: Inside a short pulse, a `txir_i` pulse sets `mode_o` to 2'b10 when the pulse closes, whatever the level of `txir_i` at the falling edge. The `txir_i` pulse must rise at least SETUP_CYC cycles (50) after the first high sample of `sd_i`, stay high at least RCW_CYC cycles (50), and fall while `sd_i` is still high.
- R6: A pulse longer than PROG_CYC but shorter than SHUT_CYC cycles leaves `mode_o` unchanged and sets `proto_err_o`. `proto_err_o` returns to 0 one cycle after the next high sample of `sd_i`.
- R7: `tx_o` equals `txir_i` only while the block is running and `sd_i` is low. In every other case it is 0, and toggling `txir_i` while running does not change `mode_o`.
- R8: `prog_busy_o` is 1 from the cycle after `sd_i` is first sampled high until the cycle after it is sampled low, or until shutdown starts. It is never 1 together with `shutdown_o`.
- R9: A `txir_i` pulse that rises fewer than SETUP_CYC cycles after the shutdown line rises does not select remote control. Neither does one narrower than RCW_CYC cycles. In both cases the level captured at the falling edge decides the mode.
- R10: A pulse of exactly PROG_CYC cycles programs the mode. PROG_CYC+1 cycles is a protocol error. SHUT_CYC−1 cycles is a protocol error without shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_i | input | 1 | Synchronized shutdown/programming line, active high |
| txir_i | input | 1 | Synchronized infrared transmit-data line |
| mode_o | output | 2 | Current mode: 00 SIR, 01 FAST, 10 remote control |
| shutdown_o | output | 1 | Full shutdown in effect |
| prog_busy_o | output | 1 | Shutdown-line pulse being measured |
| proto_err_o | output | 1 | Last pulse had an intermediate, invalid length |
| tx_o | output | 1 | Transmit data passed to the emitter path |

## Verification
Two functions can act in one cycle: completion of a remote-control pulse, and the falling-edge capture that closes the window. The bench places the `txir_i` pulse so that it ends within the last few cycles before the shutdown line falls, and sometimes holds `txir_i` high into the capture. The bench's own model then decides whether the pulse counted as complete, and so whether remote control or the captured level wins. The pulse-length thresholds are approached from both sides by directed lengths and by random lengths near each limit.

// File: rtl/sdmode_pkg.sv
package sdmode_pkg;
    typedef enum logic [1:0] {
        MODE_SIR  = 2'b00,
        MODE_FAST = 2'b01,
        MODE_RC   = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_PROG = 2'b01,
        ST_SHUT = 2'b10
    } st_e;
endpackage

// File: rtl/sdmode_span_timer.sv
// Saturating cycle counter: restart loads 1 or 0 depending on step.
module sdmode_span_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= step ? ONE : '0;
        end else if (step && (count != '1)) begin
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/sdmode_rc_detect.sv
// Detects a qualifying transmit-data pulse inside the programming window.
module sdmode_rc_detect #(
    parameter int             W         = 8,
    parameter logic [W-1:0]   SETUP_LIM = '0,
    parameter logic [W-1:0]   WIDTH_LIM = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         window,
    input  logic         txir,
    input  logic [W-1:0] sd_count,
    output logic         rc_hit
);
    logic         tx_q;
    logic         start_ok;
    logic         rise;
    logic         fall;
    logic [W-1:0] pw_count;

    assign rise = window & txir & ~tx_q;
    assign fall = window & ~txir & tx_q;

    sdmode_span_timer #(.W(W)) u_pw (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rise),
        .step    (txir),
        .count   (pw_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= 1'b0;
            start_ok <= 1'b0;
            rc_hit   <= 1'b0;
        end else begin
            tx_q <= txir;
            if (!window) begin
                start_ok <= 1'b0;
                rc_hit   <= 1'b0;
            end else begin
                if (rise) begin
                    start_ok <= (sd_count >= SETUP_LIM);
                end
                if (fall && start_ok && (pw_count >= WIDTH_LIM)) begin
                    rc_hit <= 1'b1;
                end
            end
        end
    end

    // R5: a hit can only appear after a cycle spent inside the window
    p_hit_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_hit) |-> $past(window));

    // R9: a hit is only raised on the cycle after a falling transmit edge
    p_hit_needs_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_hit) |-> ($past(tx_q) && !$past(txir)));
endmodule

// File: rtl/sd_mode_decoder.sv
module sd_mode_decoder
    import sdmode_pkg::*;
#(
    parameter int CLK_HZ      = 250_000_000,
    parameter int PROG_MAX_NS = 5000,
    parameter int SHUT_MIN_NS = 30000,
    parameter int SETUP_NS    = 200,
    parameter int RC_MIN_NS   = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sd_i,
    input  logic       txir_i,
    output logic [1:0] mode_o,
    output logic       shutdown_o,
    output logic       prog_busy_o,
    output logic       proto_err_o,
    output logic       tx_o
);
    localparam int PROG_CYC  = int'((64'(PROG_MAX_NS) * 64'(CLK_HZ)) / 64'd1000000000);
    localparam int SHUT_CYC  = int'((64'(SHUT_MIN_NS) * 64'(CLK_HZ)) / 64'd1000000000);
    localparam int SETUP_CYC = int'((64'(SETUP_NS) * 64'(CLK_HZ)) / 64'd1000000000);
    localparam int RCW_CYC   = int'((64'(RC_MIN_NS) * 64'(CLK_HZ)) / 64'd1000000000);
    localparam int CW        = $clog2(SHUT_CYC + 1);

    localparam logic [CW-1:0] PROG_LIM  = CW'(PROG_CYC);
    localparam logic [CW-1:0] SHUT_M1   = CW'(SHUT_CYC - 1);
    localparam logic [CW-1:0] SETUP_LIM = CW'(SETUP_CYC);
    localparam logic [CW-1:0] RCW_LIM   = CW'(RCW_CYC);

    st_e           state_q;
    st_e           state_d;
    mode_e         mode_q;
    logic          err_q;
    logic [CW-1:0] sd_cnt;
    logic          in_prog;
    logic          rc_hit;
    logic          reach_shut;
    logic          short_ok;

    assign in_prog    = (state_q == ST_PROG);
    assign reach_shut = sd_i && (sd_cnt == SHUT_M1);
    assign short_ok   = (sd_cnt <= PROG_LIM);

    sdmode_span_timer #(.W(CW)) u_sd_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (!in_prog),
        .step    (sd_i),
        .count   (sd_cnt)
    );

    sdmode_rc_detect #(
        .W         (CW),
        .SETUP_LIM (SETUP_LIM),
        .WIDTH_LIM (RCW_LIM)
    ) u_rc (
        .clk      (clk),
        .rst_n    (rst_n),
        .window   (in_prog),
        .txir     (txir_i),
        .sd_count (sd_cnt),
        .rc_hit   (rc_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (sd_i) state_d = ST_PROG;
            ST_PROG: begin
                if (!sd_i)           state_d = ST_RUN;
                else if (reach_shut) state_d = ST_SHUT;
            end
            ST_SHUT: if (!sd_i) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Output registers: mode and protocol error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SIR;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: if (sd_i) err_q <= 1'b0;
                ST_PROG: begin
                    if (!sd_i) begin
                        if (short_ok) begin
                            if (rc_hit)      mode_q <= MODE_RC;
                            else if (txir_i) mode_q <= MODE_FAST;
                            else             mode_q <= MODE_SIR;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end else if (reach_shut) begin
                        mode_q <= MODE_SIR;
                    end
                end
                ST_SHUT: ;
                default: ;
            endcase
        end
    end

    assign mode_o      = mode_q;
    assign proto_err_o = err_q;
    assign shutdown_o  = (state_q == ST_SHUT);
    assign prog_busy_o = in_prog;
    assign tx_o        = (state_q == ST_RUN) & ~sd_i & txir_i;

    // R4: shutdown always shows the default mode
    p_shut_sir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> (mode_o == 2'b00));

    // R4: shutdown is only entered from a measured pulse
    p_shut_from_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_o) |-> $past(prog_busy_o));

    // R8: measuring and shutdown never overlap
    p_busy_shut_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_busy_o && shutdown_o));

    // R7: nothing reaches the emitter path during a window or shutdown
    p_no_tx_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy_o || shutdown_o) |-> !tx_o);

    // R6: a protocol error never alters the mode
    p_err_keeps_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err_o) |-> $stable(mode_o));

    // R2: mode only moves at the end of a measured pulse or at shutdown
    p_mode_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_busy_o && !$past(prog_busy_o)) |-> $stable(mode_o));
endmodule

// File: tb/sd_mode_decoder_test.sv
`timescale 1ns/1ps
module sd_mode_decoder_test;
    localparam int PROG  = 1250;
    localparam int SHUT  = 7500;
    localparam int SETUP = 50;
    localparam int RCW   = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sd_i = 1'b0;
    logic       txir_i = 1'b0;
    logic [1:0] mode_o;
    logic       shutdown_o, prog_busy_o, proto_err_o, tx_o;

    int checks = 0;
    int errors = 0;
    int exp_mode = 0;
    int long_used = 0;

    always #2 clk = ~clk;

    sd_mode_decoder uut (
        .clk(clk), .rst_n(rst_n), .sd_i(sd_i), .txir_i(txir_i),
        .mode_o(mode_o), .shutdown_o(shutdown_o), .prog_busy_o(prog_busy_o),
        .proto_err_o(proto_err_o), .tx_o(tx_o)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit rc_valid(int h, int r, int w, bit tf);
        if (r < SETUP || w < RCW || r + w >= h) return 1'b0;
        if (tf && (r + w >= h - 3)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int model_mode(int prev, int h, int r, int w, bit tf);
        if (h >= SHUT) return 0;
        if (h > PROG) return prev;
        if (rc_valid(h, r, w, tf)) return 2;
        return tf ? 1 : 0;
    endfunction

    // h: cycles with sd high; r/w: txir pulse start index and width (r<0: none)
    task automatic run_pulse(string tag, int h, int r, int w, bit tf);
        int bad_busy = 0;
        int bad_shut = 0;
        int bad_tx = 0;
        int bad_clr = 0;
        int e_mode;
        for (int i = 0; i <= h; i++) begin
            @(negedge clk);
            if (i >= 1) begin
                if (int'(prog_busy_o) != int'(i < SHUT)) bad_busy++;
                if (int'(shutdown_o) != int'(i >= SHUT)) bad_shut++;
                if (i == 1 && proto_err_o) bad_clr++;
            end
            if (i < h) begin
                sd_i = 1'b1;
                if (r >= 0 && i >= r && i < r + w) txir_i = 1'b1;
                else if (i >= h - 3) txir_i = tf;
                else txir_i = 1'b0;
                #1;
                if (tx_o) bad_tx++;
            end
        end
        sd_i = 1'b0;
        txir_i = tf;
        @(negedge clk);
        txir_i = 1'b0;
        repeat (3) @(negedge clk);
        e_mode = model_mode(exp_mode, h, r, w, tf);
        exp_mode = e_mode;
        chk({tag, " R8 busy timing"}, bad_busy, 0);
        chk({tag, " R4 shutdown timing"}, bad_shut, 0);
        chk({tag, " R7 tx gated while sd high"}, bad_tx, 0);
        if (h >= 2) chk({tag, " R6 error cleared on rise"}, bad_clr, 0);
        chk({tag, " R2/R3/R5 mode"}, int'(mode_o), e_mode);
        chk({tag, " R6 proto_err"}, int'(proto_err_o), int'(h > PROG && h < SHUT));
        chk({tag, " R4 released"}, int'(shutdown_o) + int'(prog_busy_o), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", int'(mode_o), 0);
        chk("R1 flags", int'(shutdown_o) + int'(prog_busy_o) + int'(proto_err_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 pass-through while running
        txir_i = 1'b1; #1;
        chk("R7 tx follows txir", int'(tx_o), 1);
        @(negedge clk); txir_i = 1'b0; #1;
        chk("R7 tx low", int'(tx_o), 0);
        chk("R7 mode untouched", int'(mode_o), 0);

        run_pulse("R2 fast",        100, -1, 0, 1'b1);
        run_pulse("R3 sir",         100, -1, 0, 1'b0);
        run_pulse("R10 exact prog", PROG, -1, 0, 1'b1);
        run_pulse("R10 prog+1 R6",  PROG + 1, -1, 0, 1'b0);
        run_pulse("R5 rc priority", 200, SETUP, RCW, 1'b1);
        run_pulse("R9 early pulse", 200, SETUP - 1, 60, 1'b1);
        run_pulse("R9 narrow pulse",200, 60, RCW - 1, 1'b0);
        run_pulse("R5 rc again",    300, 70, 80, 1'b0);
        run_pulse("R10 shut-1",     SHUT - 1, -1, 0, 1'b1);
        run_pulse("R4 shutdown",    SHUT + 20, 60, 60, 1'b1);
        run_pulse("R5 rc to end",   150, 60, 87, 1'b1);

        for (int k = 0; k < 16; k++) begin
            int cat = $urandom_range(0, 9);
            int h;
            int r = $urandom_range(0, 120);
            int w = $urandom_range(30, 90);
            bit tf = 1'($urandom_range(0, 1));
            if (cat >= 9 && long_used < 3) begin
                long_used++;
                h = SHUT + $urandom_range(0, 40);
            end else if (cat >= 7) begin
                h = PROG + 1 + $urandom_range(0, 700);
            end else if (cat == 6) begin
                h = PROG - $urandom_range(0, 3);
            end else begin
                h = $urandom_range(2, 260);
            end
            if (cat == 0) r = -1;
            run_pulse("R5/R9 random", h, r, w, tf);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule